// File: doc/BRIEF.md
# I2C Register Target with Byte and Block Transfers

This block is a bus target on a two-wire serial link. It holds a bank of eight 8-bit control registers and drives every register out in parallel to the logic around it. A controller can reach the bank in four ways: write one register, read one register, write a run of registers, or read a run of registers. A run is framed by a count byte. The controller supplies that byte on writes, and the target sends it first on reads.

SCL and SDA are sampled by a fast system clock through a two-stage synchronizer. SDA is never driven high. The target only pulls it low through an enable, and the pad logic outside the block turns that enable into an open-drain output. Start, repeated start and stop are detected from the synchronized lines. The controller sets the transfer type and the starting register in one command byte. Bit 7 set selects a single-byte transfer. Bit 7 clear selects a counted run. The low three bits give the register index.

Top module: `i2c_regbank_target`

## Requirements
- R1: While reset is high and on the cycle after it, every register output reads 0x00 and the SDA pull-down enable is 0.
- R2: The target acknowledges an address byte of 0xD6 (write) or 0xD7 (read), which is 7-bit address 0x6B. It does not acknowledge any other address and then ignores every byte until the next start condition.
- R3: The target acknowledges the command byte that follows a write address. Command bit 7 = 1 selects single-byte mode and bit 7 = 0 selects counted mode. Bits 2:0 give the starting register index.
- R4: In single-byte mode, the first data byte written is stored in the indexed register. Later data bytes in the same transaction are acknowledged and have no effect.
- R5: In counted mode, the first byte after the command is the byte count. The data bytes that follow go to consecutive registers starting at the index, each is acknowledged, and the index wraps from 7 back to 0.
- R6: In counted mode, data bytes beyond the byte count are acknowledged and leave every register unchanged.
- R7: A counted read (command, repeated start, read address) first returns 8 minus the start index, then the registers from the index upward, wrapping from 7 back to 0, for as long as the controller acknowledges.
- R8: A single-byte read returns the contents of the indexed register.
- R9: After the controller NACKs a read byte, the target releases SDA and drives nothing more until the next start. Further clocks read back 0xFF.
- R10: A stop or start condition at any point, including in the middle of a byte, abandons the transfer in progress. A partial byte changes no register, and the next transaction works normally.
- R11: Every byte moves most significant bit first in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | NUM_REGS*8 | Register contents; register k sits in bits 8k+7:8k |

## Verification
The bench goes after the wrap of the index from register 7 to register 0. A design that got this wrong would write or read past the bank, or restart at the wrong register. It writes more bytes than the count allows and then checks the neighbouring register, which a design that ignores the count would overwrite. It sends extra clocks after a NACK, which a target that kept transmitting would answer with register data instead of 0xFF. It aborts a write halfway through a byte with a stop, which a design that commits partial bytes would turn into a corrupted register. It writes 0x01 and checks that it reads as 0x01, because a bit-order error would leave 0x80 in the register.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,  // not addressed, ignoring the bus
    PH_RX,    // shifting a byte in from the controller
    PH_ACK,   // holding SDA low for our acknowledge
    PH_TX,    // shifting a byte out to the controller
    PH_MACK   // sampling the controller's acknowledge
  } phase_t;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_CMD,
    BY_DATA
  } byte_kind_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_STAGES-1];
      sda_d  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA edges are only conditions when SCL is high on both samples
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NUM_REGS = 8,
  parameter int DW       = 8,
  localparam int AW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [DW-1:0]          wdata,
  input  logic [AW-1:0]          raddr,
  output logic [DW-1:0]          rdata,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  logic [DW-1:0] mem [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                            mem[k] <= '0;
      else if (we && waddr == AW'(k))     mem[k] <= wdata;
    end
    assign regs_o[k*DW +: DW] = mem[k];
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [6:0] TGT_ADDR = 7'h6B,
  localparam int        AW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] raddr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic          sda_oe
);
  phase_t     phase;
  byte_kind_t kind;
  logic [2:0] bit_cnt;
  logic       got;
  logic [7:0] shreg, tx_sr;
  logic       rd_dir, byte_mode, cnt_known, cnt_sent, m_ack;
  logic [7:0] limit, wr_n;
  logic [AW-1:0] ptr, ptr_next;
  logic [7:0] remain;

  assign ptr_next = (ptr == AW'(NUM_REGS-1)) ? '0 : ptr + 1'b1;
  assign remain   = 8'(NUM_REGS) - 8'(ptr);
  assign raddr    = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;  kind <= BY_ADDR;  bit_cnt <= '0;  got <= 1'b0;
      shreg <= '0;  tx_sr <= '0;  rd_dir <= 1'b0;  byte_mode <= 1'b0;
      cnt_known <= 1'b0;  cnt_sent <= 1'b0;  m_ack <= 1'b0;
      limit <= '0;  wr_n <= '0;  ptr <= '0;
      we <= 1'b0;  waddr <= '0;  wdata <= '0;  sda_oe <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        phase <= PH_RX;  kind <= BY_ADDR;  bit_cnt <= '0;
        got <= 1'b0;  sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase <= PH_IDLE;  sda_oe <= 1'b0;  got <= 1'b0;
      end else begin
        unique case (phase)
          PH_RX: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == 3'd7) got <= 1'b1;
            end else if (scl_fall && got) begin
              got     <= 1'b0;
              bit_cnt <= '0;
              unique case (kind)
                BY_ADDR: begin
                  if (shreg[7:1] == TGT_ADDR) begin
                    rd_dir <= shreg[0];
                    kind   <= BY_CMD;
                    sda_oe <= 1'b1;
                    phase  <= PH_ACK;
                  end else begin
                    phase  <= PH_IDLE;
                  end
                end
                BY_CMD: begin
                  ptr       <= shreg[AW-1:0];
                  byte_mode <= shreg[7];
                  cnt_known <= shreg[7];
                  limit     <= 8'd1;
                  wr_n      <= '0;
                  cnt_sent  <= 1'b0;
                  kind      <= BY_DATA;
                  sda_oe    <= 1'b1;
                  phase     <= PH_ACK;
                end
                default: begin
                  if (!cnt_known) begin
                    limit     <= shreg;
                    cnt_known <= 1'b1;
                  end else if (wr_n < limit) begin
                    we    <= 1'b1;
                    waddr <= ptr;
                    wdata <= shreg;
                    wr_n  <= wr_n + 1'b1;
                    ptr   <= ptr_next;
                  end
                  sda_oe <= 1'b1;
                  phase  <= PH_ACK;
                end
              endcase
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_dir) begin
                phase <= PH_TX;
                if (!byte_mode && !cnt_sent) begin
                  tx_sr <= remain;  sda_oe <= ~remain[7];  cnt_sent <= 1'b1;
                end else begin
                  tx_sr <= rd_data;  sda_oe <= ~rd_data[7];  ptr <= ptr_next;
                end
              end else begin
                sda_oe <= 1'b0;
                phase  <= PH_RX;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == 3'd7) begin
                sda_oe <= 1'b0;
                phase  <= PH_MACK;
              end else begin
                tx_sr  <= {tx_sr[6:0], 1'b0};
                sda_oe <= ~tx_sr[6];
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (m_ack) begin
                phase <= PH_TX;
                if (!byte_mode && !cnt_sent) begin
                  tx_sr <= remain;  sda_oe <= ~remain[7];  cnt_sent <= 1'b1;
                end else begin
                  tx_sr <= rd_data;  sda_oe <= ~rd_data[7];  ptr <= ptr_next;
                end
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
  parameter int         NUM_REGS    = 8,
  parameter logic [6:0] TGT_ADDR    = 7'h6B,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic we;
  logic [AW-1:0] waddr, raddr;
  logic [7:0] wdata, rdata;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_ctrl #(.NUM_REGS(NUM_REGS), .TGT_ADDR(TGT_ADDR)) i_ctrl (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rdata), .raddr(raddr),
    .we(we), .waddr(waddr), .wdata(wdata), .sda_oe(sda_oe)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .DW(8)) i_bank (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata), .regs_o(regs_o)
  );
endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_s,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] regs_o
);
  logic [NUM_REGS*8-1:0] regs_prev;
  logic [NUM_REGS-1:0]   chg;

  always_ff @(posedge clk) regs_prev <= regs_o;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_chg
    assign chg[k] = regs_o[k*8 +: 8] != regs_prev[k*8 +: 8];
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!sda_oe && regs_o == '0));

  // R10
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R10
  reg_change_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(regs_o) |-> !scl_s);

  // R5
  one_reg_per_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chg));
endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.NUM_REGS(NUM_REGS)) i_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .regs_o(regs_o)
);

// File: tb/test_i2c_regbank_target.sv
module test_i2c_regbank_target;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [63:0] regs_o;
  logic sda_bus;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_regbank_target i_i2c_regbank_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] mdl [8];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] act_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic q_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; q_wait(Q); scl_m = 1'b1; q_wait(Q);
    sda_m = 1'b0; q_wait(Q); scl_m = 1'b0; q_wait(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; q_wait(Q); scl_m = 1'b1; q_wait(Q);
    sda_m = 1'b1; q_wait(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sda_m = b[7-i]; q_wait(Q); scl_m = 1'b1; q_wait(2*Q); scl_m = 1'b0; q_wait(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; q_wait(Q); scl_m = 1'b1; q_wait(Q);
    ack = (sda_bus == 1'b0);
    q_wait(Q); scl_m = 1'b0; q_wait(Q);
  endtask

  task automatic recv_byte(input bit give_ack);
    logic [7:0] b;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; q_wait(Q); scl_m = 1'b1; q_wait(Q);
      b = {b[6:0], sda_bus};
      q_wait(Q); scl_m = 1'b0; q_wait(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    q_wait(Q); scl_m = 1'b1; q_wait(2*Q); scl_m = 1'b0; q_wait(Q);
    sda_m = 1'b1;
    act_q.push_back(b);
  endtask

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor: compares every byte the target returns
  initial begin
    forever begin
      wait (act_q.size() > 0);
      begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(a == e, t, a, e);
      end
    end
  end

  task automatic chk_regs(input string tag);
    for (int k = 0; k < 8; k++)
      chk(regs_o[k*8 +: 8] == mdl[k], tag, regs_o[k*8 +: 8], mdl[k]);
  endtask

  task automatic head(input logic [7:0] cmd);
    bit a;
    i2c_start();
    send_byte(8'hD6, a); chk(a, "R2 address ack", a, 1);
    send_byte(cmd, a);   chk(a, "R3 command ack", a, 1);
  endtask

  task automatic wr_bytes(input logic [2:0] idx, input logic [7:0] d [], input string tag);
    bit a;
    head(8'h80 | idx);
    foreach (d[i]) begin
      send_byte(d[i], a); chk(a, tag, a, 1);
    end
    i2c_stop();
    mdl[idx] = d[0];
  endtask

  task automatic blk_wr(input logic [2:0] idx, input logic [7:0] cnt,
                        input logic [7:0] d [], input string tag);
    bit a;
    head({5'b0, idx});
    send_byte(cnt, a); chk(a, "R5 count ack", a, 1);
    foreach (d[i]) begin
      send_byte(d[i], a); chk(a, tag, a, 1);
      if (i < cnt) mdl[(idx + i) % 8] = d[i];
    end
    i2c_stop();
  endtask

  task automatic rd_start(input logic [7:0] cmd);
    bit a;
    head(cmd);
    i2c_start();
    send_byte(8'hD7, a); chk(a, "R2 read address ack", a, 1);
  endtask

  task automatic drain();
    wait (act_q.size() == 0);
    q_wait(4);
  endtask

  initial begin
    bit a;
    for (int k = 0; k < 8; k++) mdl[k] = '0;
    repeat (5) @(negedge clk);
    chk(regs_o == '0, "R1 regs during reset", 0, 0);
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    rst = 1'b0;
    q_wait(4);

    // R4 single write, R8 single read
    wr_bytes(3'd3, '{8'hA5}, "R4 data ack");
    q_wait(4); chk_regs("R4 single write");
    rd_start(8'h83);
    expect_rd(8'hA5, "R8 single read");
    recv_byte(1'b0);
    i2c_stop(); drain();

    // R4 extra byte ignored
    wr_bytes(3'd5, '{8'h3C, 8'h77}, "R4 extra byte ack");
    q_wait(4); chk_regs("R4 extra byte ignored");

    // R11 bit order
    wr_bytes(3'd7, '{8'h01}, "R11 data ack");
    q_wait(4);
    chk(regs_o[63:56] == 8'h01, "R11 msb first", regs_o[63:56], 8'h01);
    mdl[7] = 8'h01;

    // R5 block write with wrap
    blk_wr(3'd6, 8'd4, '{8'h11, 8'h22, 8'h33, 8'h44}, "R5 data ack");
    q_wait(4); chk_regs("R5 block write wrap");

    // R6 bytes beyond count
    blk_wr(3'd2, 8'd2, '{8'h55, 8'h66, 8'h77}, "R6 excess byte ack");
    q_wait(4); chk_regs("R6 beyond count");

    // R7 block read with wrap
    rd_start(8'h06);
    expect_rd(8'd2, "R7 count byte");
    recv_byte(1'b1);
    for (int i = 0; i < 4; i++) begin
      expect_rd(mdl[(6 + i) % 8], "R7 block data");
      recv_byte(i != 3);
    end
    i2c_stop(); drain();

    // R7 count from index 0
    rd_start(8'h00);
    expect_rd(8'd8, "R7 count from 0");
    recv_byte(1'b1);
    expect_rd(mdl[0], "R7 first reg");
    recv_byte(1'b0);
    i2c_stop(); drain();

    // R2 wrong address ignored
    i2c_start();
    send_byte(8'hA0, a); chk(!a, "R2 foreign address nack", a, 0);
    send_byte(8'h81, a); chk(!a, "R2 ignored command", a, 0);
    send_byte(8'hEE, a); chk(!a, "R2 ignored data", a, 0);
    i2c_stop();
    q_wait(4); chk_regs("R2 regs unchanged");

    // R9 no drive after controller NACK
    rd_start(8'h83);
    expect_rd(mdl[3], "R8 single read again");
    recv_byte(1'b0);
    expect_rd(8'hFF, "R9 released after nack");
    recv_byte(1'b0);
    i2c_stop(); drain();

    // R10 abort mid-byte
    head(8'h00);
    send_byte(8'd1, a);
    send_bits(8'hF0, 4);
    i2c_stop();
    q_wait(4); chk_regs("R10 partial byte dropped");
    wr_bytes(3'd0, '{8'h9B}, "R10 recovery ack");
    q_wait(4); chk_regs("R10 recovery write");

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule